// File: doc/BRIEF.md
# Machine Cycle Rate Controller with Switchback

This block decides how many input clocks form one machine cycle. It emits a single-clock machine-cycle strobe and a matching peripheral clock enable. Peripherals therefore slow down by the same factor as the core whenever a reduced rate is active. Software selects the rate through a small register write port that carries a 2-bit divide code and a switchback enable bit.

A newly written rate does not apply at once. The machine cycle in progress and one further machine cycle run at the old rate, and the new rate starts after that. The block will not move directly from one slow rate to the other. Reset requests of every kind return the block to the fastest rate. When switchback is enabled, the block also returns to the fastest rate at once on any of three events: a start bit on the serial receive line, a write to the serial transmit buffer, or a qualified interrupt acknowledge.

Top module: `mc_rate_ctrl`

## Requirements
- R1: After any reset the active code is 01 (fastest rate, FAST_CLKS clocks per machine cycle) and switchback is disabled. Code 10 selects MID_CLKS and code 11 selects SLOW_CLKS; `activeDiv` reports the active code and `swbEnabled` reports the switchback bit.
- R2: `mcStrobe` is a one-clock pulse once every N clocks, where N is the clock count of the active code. `periphEn` pulses in the same cycles as `mcStrobe`.
- R3: An accepted divide write does not change `activeDiv` at the first strobe after the write. The new code becomes active at the second strobe, and the counter reloads with the new rate at that point.
- R4: A write of code 00 leaves both the active code and any pending code unchanged.
- R5: A write of code 10 or 11 is rejected when the active code, or a pending code, is the other slow code.
- R6: While switchback is enabled, any of three events sets `activeDiv` to 01 on the next clock, restarts the count and discards any pending code. The events are a high-to-low change of `rxLine` while `rxEnable` is 1, a `txBufWr` pulse, or an `extIntAck` pulse. No serial interrupt flag is an input.
- R7: With switchback disabled, the trigger events have no effect on the rate. A falling edge of `rxLine` while `rxEnable` is 0 is never a trigger.
- R8: While switchback is enabled and `serialBusy` is 1, the divide field of a write is ignored. The switchback bit of the same write is still stored.
- R9: A one-clock pulse on `wdtRstReq`, `extRstReq` or `pwrFailReq` has the same effect as `rstN` on the next clock: code 01, switchback cleared, count restarted.
- R10: After a switchback, software may write a slow code again, and it takes effect as R3 describes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| wdtRstReq | input | 1 | Watchdog reset request, synchronous |
| extRstReq | input | 1 | External pin reset request, synchronous |
| pwrFailReq | input | 1 | Power-fail reset request, synchronous |
| cfgWrEn | input | 1 | Register write strobe |
| cfgDiv | input | 2 | Requested divide code |
| cfgSwbEn | input | 1 | Switchback enable value written |
| rxLine | input | 1 | Serial receive line level |
| rxEnable | input | 1 | Serial reception enabled |
| txBufWr | input | 1 | Write to the serial transmit buffer |
| extIntAck | input | 1 | Enabled external interrupt acknowledged without blocking |
| serialBusy | input | 1 | Serial transmit or receive in progress |
| mcStrobe | output | 1 | Machine-cycle strobe |
| periphEn | output | 1 | Peripheral clock enable |
| activeDiv | output | 2 | Active divide code |
| swbEnabled | output | 1 | Stored switchback enable |

## Verification
The bench builds the block with FAST_CLKS=4, MID_CLKS=8 and SLOW_CLKS=12. With these values the slowest machine cycle lasts only twelve clocks. Deferred application over two boundaries, rejection of slow-to-slow moves and switchback out of each slow rate can therefore all be exercised many times within a short run. Because the three rates are distinct, a wrongly selected reload value shows up as a wrong strobe spacing. The 10-bit counter that the default 1024 needs is reached only by elaboration with the default values.

// File: rtl/mcr_pkg.sv
package mcr_pkg;

  typedef enum logic [1:0] {
    CODE_RSVD = 2'b00,
    CODE_FAST = 2'b01,
    CODE_MID  = 2'b10,
    CODE_SLOW = 2'b11
  } divCode_e;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic     clearAll;
    logic     forceFast;
    logic     applyNew;
    divCode_e newCode;
  } rateCtl_t;

  function automatic logic slowClash(input logic [1:0] a, input logic [1:0] b);
    return a[1] & b[1] & (a != b);
  endfunction

endpackage

// File: rtl/mcr_ctrl.sv
module mcr_ctrl
  import mcr_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     resetReq,
  input  logic     cfgWrEn,
  input  logic [1:0] cfgDiv,
  input  logic     cfgSwbEn,
  input  logic     rxLine,
  input  logic     rxEnable,
  input  logic     txBufWr,
  input  logic     extIntAck,
  input  logic     serialBusy,
  input  logic     mcStrobe,
  input  divCode_e activeDiv,
  output rateCtl_t ctl,
  output logic     swbEn
);

  logic     swbEnQ;
  logic     rxPrevQ;
  logic     pendValidQ;
  logic     pendArmedQ;
  divCode_e pendCodeQ;

  logic rxFall;
  logic trigger;
  logic writeOk;

  assign rxFall  = rxPrevQ & ~rxLine & rxEnable;
  assign trigger = swbEnQ & (rxFall | txBufWr | extIntAck);

  assign writeOk = cfgWrEn
                 & (cfgDiv != CODE_RSVD)
                 & ~(swbEnQ & serialBusy)
                 & ~slowClash(activeDiv, cfgDiv)
                 & ~(pendValidQ & slowClash(pendCodeQ, cfgDiv))
                 & ~trigger;

  always_comb begin
    ctl.clearAll  = resetReq;
    ctl.forceFast = trigger & ~resetReq;
    ctl.applyNew  = mcStrobe & pendValidQ & pendArmedQ & ~trigger & ~resetReq;
    ctl.newCode   = pendCodeQ;
  end

  assign swbEn = swbEnQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swbEnQ     <= 1'b0;
      rxPrevQ    <= 1'b1;
      pendValidQ <= 1'b0;
      pendArmedQ <= 1'b0;
      pendCodeQ  <= CODE_FAST;
    end else if (resetReq) begin
      swbEnQ     <= 1'b0;
      rxPrevQ    <= 1'b1;
      pendValidQ <= 1'b0;
      pendArmedQ <= 1'b0;
      pendCodeQ  <= CODE_FAST;
    end else begin
      rxPrevQ <= rxLine;
      if (cfgWrEn) swbEnQ <= cfgSwbEn;
      if (trigger) begin
        pendValidQ <= 1'b0;
        pendArmedQ <= 1'b0;
      end else if (writeOk) begin
        pendCodeQ  <= divCode_e'(cfgDiv);
        pendValidQ <= 1'b1;
        pendArmedQ <= 1'b0;
      end else if (mcStrobe && pendValidQ) begin
        if (pendArmedQ) begin
          pendValidQ <= 1'b0;
          pendArmedQ <= 1'b0;
        end else begin
          pendArmedQ <= 1'b1;
        end
      end
    end
  end

  // R8: busy serial with switchback keeps the pending code
  a_r8_busy_lock: assert property (@(posedge clk) disable iff (!rstN)
    (swbEnQ && serialBusy && cfgWrEn && !resetReq) |=> (pendCodeQ == $past(pendCodeQ)));

  // R4: reserved code is never taken as pending
  a_r4_reserved_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgDiv == 2'b00 && !resetReq) |=> (pendCodeQ == $past(pendCodeQ)));

  // R6: a trigger discards any pending code
  a_r6_trigger_drops: assert property (@(posedge clk) disable iff (!rstN)
    (trigger && !resetReq) |=> !pendValidQ);

endmodule

// File: rtl/mcr_datapath.sv
module mcr_datapath
  import mcr_pkg::*;
#(
  parameter int FAST_CLKS = 4,
  parameter int MID_CLKS  = 64,
  parameter int SLOW_CLKS = 1024
) (
  input  logic     clk,
  input  logic     rstN,
  input  rateCtl_t ctl,
  output logic     mcStrobe,
  output logic     periphEn,
  output divCode_e activeDiv
);

  localparam int CW = $clog2(SLOW_CLKS);
  localparam logic [CW-1:0] FAST_LAST = CW'(FAST_CLKS - 1);
  localparam logic [CW-1:0] MID_LAST  = CW'(MID_CLKS - 1);
  localparam logic [CW-1:0] SLOW_LAST = CW'(SLOW_CLKS - 1);

  logic [CW-1:0] cntQ;
  logic [CW-1:0] cntNext;
  divCode_e      activeQ;
  divCode_e      activeNext;
  logic          restart;

  function automatic logic [CW-1:0] lastOf(input divCode_e c);
    case (c)
      CODE_MID:  return MID_LAST;
      CODE_SLOW: return SLOW_LAST;
      default:   return FAST_LAST;
    endcase
  endfunction

  assign mcStrobe  = (cntQ == '0);
  assign periphEn  = mcStrobe;
  assign activeDiv = activeQ;

  always_comb begin
    if (ctl.clearAll || ctl.forceFast) activeNext = CODE_FAST;
    else if (ctl.applyNew)             activeNext = ctl.newCode;
    else                               activeNext = activeQ;
  end

  assign restart = ctl.clearAll | (ctl.forceFast & (activeQ != CODE_FAST));

  always_comb begin
    if (restart)       cntNext = FAST_LAST;
    else if (mcStrobe) cntNext = lastOf(activeNext);
    else               cntNext = cntQ - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ    <= FAST_LAST;
      activeQ <= CODE_FAST;
    end else begin
      cntQ    <= cntNext;
      activeQ <= activeNext;
    end
  end

  // R1: reserved code never becomes active
  a_r1_never_reserved: assert property (@(posedge clk) disable iff (!rstN)
    activeQ != CODE_RSVD);

  // R2: count stays within the active period
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= lastOf(activeQ));

  // R3: the rate changes only at a boundary or by a forced return
  a_r3_change_at_boundary: assert property (@(posedge clk) disable iff (!rstN)
    (activeQ != $past(activeQ)) |-> ($past(mcStrobe) || $past(ctl.forceFast) || $past(ctl.clearAll)));

  // R5: no move between the two slow rates
  a_r5_no_slow_jump: assert property (@(posedge clk) disable iff (!rstN)
    (activeQ[1] && $past(activeQ[1])) |-> (activeQ == $past(activeQ)));

  // R6: a forced return lands on the fastest rate
  a_r6_force_fast: assert property (@(posedge clk) disable iff (!rstN)
    ctl.forceFast |=> (activeQ == CODE_FAST));

  // R9: reset requests restart at the fastest rate
  a_r9_clear_fast: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clearAll |=> (activeQ == CODE_FAST && cntQ == FAST_LAST));

endmodule

// File: rtl/mc_rate_ctrl.sv
module mc_rate_ctrl
  import mcr_pkg::*;
#(
  parameter int FAST_CLKS = 4,
  parameter int MID_CLKS  = 64,
  parameter int SLOW_CLKS = 1024
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wdtRstReq,
  input  logic       extRstReq,
  input  logic       pwrFailReq,
  input  logic       cfgWrEn,
  input  logic [1:0] cfgDiv,
  input  logic       cfgSwbEn,
  input  logic       rxLine,
  input  logic       rxEnable,
  input  logic       txBufWr,
  input  logic       extIntAck,
  input  logic       serialBusy,
  output logic       mcStrobe,
  output logic       periphEn,
  output logic [1:0] activeDiv,
  output logic       swbEnabled
);

  rateCtl_t ctl;
  divCode_e activeCode;
  logic     resetReq;

  assign resetReq  = wdtRstReq | extRstReq | pwrFailReq;
  assign activeDiv = activeCode;

  mcr_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .resetReq   (resetReq),
    .cfgWrEn    (cfgWrEn),
    .cfgDiv     (cfgDiv),
    .cfgSwbEn   (cfgSwbEn),
    .rxLine     (rxLine),
    .rxEnable   (rxEnable),
    .txBufWr    (txBufWr),
    .extIntAck  (extIntAck),
    .serialBusy (serialBusy),
    .mcStrobe   (mcStrobe),
    .activeDiv  (activeCode),
    .ctl        (ctl),
    .swbEn      (swbEnabled)
  );

  mcr_datapath #(
    .FAST_CLKS (FAST_CLKS),
    .MID_CLKS  (MID_CLKS),
    .SLOW_CLKS (SLOW_CLKS)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .mcStrobe  (mcStrobe),
    .periphEn  (periphEn),
    .activeDiv (activeCode)
  );

endmodule

// File: tb/mc_rate_ctrl_tb_top.sv
module mc_rate_ctrl_tb_top;

  localparam int F = 4;
  localparam int M = 8;
  localparam int S = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wdtRstReq = 1'b0, extRstReq = 1'b0, pwrFailReq = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [1:0] cfgDiv = 2'b01;
  logic cfgSwbEn = 1'b0;
  logic rxLine = 1'b1, rxEnable = 1'b0, txBufWr = 1'b0, extIntAck = 1'b0, serialBusy = 1'b0;
  logic mcStrobe, periphEn, swbEnabled;
  logic [1:0] activeDiv;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string tag = "R1";

  // reference model state
  int mAct = 1, mCnt = F - 1, mSwb = 0, mRxPrev = 1, mPendV = 0, mArm = 0, mPend = 1;

  always #2.5 clk = ~clk;

  mc_rate_ctrl #(.FAST_CLKS(F), .MID_CLKS(M), .SLOW_CLKS(S)) dut_i (
    .clk(clk), .rstN(rstN), .wdtRstReq(wdtRstReq), .extRstReq(extRstReq),
    .pwrFailReq(pwrFailReq), .cfgWrEn(cfgWrEn), .cfgDiv(cfgDiv), .cfgSwbEn(cfgSwbEn),
    .rxLine(rxLine), .rxEnable(rxEnable), .txBufWr(txBufWr), .extIntAck(extIntAck),
    .serialBusy(serialBusy), .mcStrobe(mcStrobe), .periphEn(periphEn),
    .activeDiv(activeDiv), .swbEnabled(swbEnabled)
  );

  function automatic int clksOf(int code);
    if (code == 2) return M;
    if (code == 3) return S;
    return F;
  endfunction

  function automatic bit clash(int a, int b);
    return (a >= 2) && (b >= 2) && (a != b);
  endfunction

  always @(posedge clk) begin
    bit strobe, trig, ok;
    int newAct, nCnt;
    cycles++;
    if (!rstN || wdtRstReq || extRstReq || pwrFailReq) begin
      mAct = 1; mCnt = F - 1; mSwb = 0; mRxPrev = 1; mPendV = 0; mArm = 0; mPend = 1;
    end else begin
      strobe = (mCnt == 0);
      trig = (mSwb != 0) && ((mRxPrev != 0 && !rxLine && rxEnable) || txBufWr || extIntAck);
      ok = cfgWrEn && cfgDiv != 0 && !(mSwb != 0 && serialBusy) && !clash(mAct, int'(cfgDiv))
           && !(mPendV != 0 && clash(mPend, int'(cfgDiv))) && !trig;
      newAct = mAct;
      if (trig) begin
        newAct = 1;
        nCnt = (mAct != 1 || strobe) ? F - 1 : mCnt - 1;
        mPendV = 0; mArm = 0;
      end else begin
        if (strobe) begin
          if (mPendV != 0 && mArm != 0) begin
            newAct = mPend; mPendV = 0; mArm = 0;
          end else if (mPendV != 0) mArm = 1;
          nCnt = clksOf(newAct) - 1;
        end else nCnt = mCnt - 1;
        if (ok) begin
          mPend = int'(cfgDiv); mPendV = 1; mArm = 0;
        end
      end
      if (cfgWrEn) mSwb = int'(cfgSwbEn);
      mRxPrev = int'(rxLine);
      mAct = newAct;
      mCnt = nCnt;
    end
  end

  task automatic expectEq(int act, int exp, string req, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model (R2 strobe, tag gives scenario)
  always @(negedge clk) begin
    expectEq(int'(mcStrobe), (mCnt == 0) ? 1 : 0, tag, "mcStrobe");
    expectEq(int'(periphEn), (mCnt == 0) ? 1 : 0, "R2", "periphEn");
    expectEq(int'(activeDiv), mAct, tag, "activeDiv");
    expectEq(int'(swbEnabled), mSwb, tag, "swbEnabled");
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeCfg(int code, bit swb);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgDiv = 2'(code); cfgSwbEn = swb;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic measurePeriod(int exp, string req);
    int n = 0;
    while (!mcStrobe) @(negedge clk);
    @(negedge clk);
    n = 1;
    while (!mcStrobe && n < 100) begin
      @(negedge clk);
      n++;
    end
    expectEq(n, exp, req, "strobe period");
  endtask

  initial begin
    step(4);
    rstN = 1'b1;
    // R1 reset state
    tag = "R1";
    expectEq(int'(activeDiv), 1, "R1", "reset code");
    expectEq(int'(swbEnabled), 0, "R1", "reset swb");
    measurePeriod(F, "R2");

    // R3 deferred application
    tag = "R3";
    writeCfg(2, 1'b0);
    while (!mcStrobe) @(negedge clk);
    expectEq(int'(activeDiv), 1, "R3", "old rate at first boundary");
    step(40);
    expectEq(int'(activeDiv), 2, "R3", "mid applied");
    measurePeriod(M, "R2");

    // R5 slow to slow rejected
    tag = "R5";
    writeCfg(3, 1'b0); step(40);
    expectEq(int'(activeDiv), 2, "R5", "slow jump rejected");

    // R4 reserved ignored
    tag = "R4";
    writeCfg(0, 1'b0); step(40);
    expectEq(int'(activeDiv), 2, "R4", "reserved ignored");

    tag = "R3";
    writeCfg(1, 1'b0); step(40);
    expectEq(int'(activeDiv), 1, "R3", "back to fast");
    writeCfg(3, 1'b0); step(40);
    expectEq(int'(activeDiv), 3, "R3", "slow applied");
    measurePeriod(S, "R2");

    // R7 rx edge without reception enabled
    tag = "R7";
    writeCfg(3, 1'b1); step(2);
    @(negedge clk) rxLine = 1'b0;
    step(3);
    expectEq(int'(activeDiv), 3, "R7", "rx edge without enable");
    rxLine = 1'b1; rxEnable = 1'b1; step(2);

    // R6 rx start bit
    tag = "R6";
    rxLine = 1'b0;
    @(negedge clk);
    expectEq(int'(activeDiv), 1, "R6", "rx start bit switchback");
    rxLine = 1'b1;
    measurePeriod(F, "R6");

    // R10 return to slow, then tx write switchback
    tag = "R10";
    writeCfg(2, 1'b1); step(40);
    expectEq(int'(activeDiv), 2, "R10", "reduced rate after switchback");
    tag = "R6";
    txBufWr = 1'b1;
    @(negedge clk) txBufWr = 1'b0;
    expectEq(int'(activeDiv), 1, "R6", "tx write switchback");

    tag = "R10";
    writeCfg(3, 1'b1); step(40);
    expectEq(int'(activeDiv), 3, "R10", "slow after switchback");
    tag = "R6";
    extIntAck = 1'b1;
    @(negedge clk) extIntAck = 1'b0;
    expectEq(int'(activeDiv), 1, "R6", "interrupt switchback");

    // R7 triggers with switchback disabled
    tag = "R7";
    writeCfg(3, 1'b0); step(40);
    extIntAck = 1'b1;
    @(negedge clk) extIntAck = 1'b0;
    step(2);
    expectEq(int'(activeDiv), 3, "R7", "ack ignored");
    txBufWr = 1'b1;
    @(negedge clk) txBufWr = 1'b0;
    step(2);
    expectEq(int'(activeDiv), 3, "R7", "tx ignored");

    // R8 busy lock
    tag = "R8";
    writeCfg(3, 1'b1);
    serialBusy = 1'b1;
    writeCfg(1, 1'b1); step(40);
    expectEq(int'(activeDiv), 3, "R8", "divide locked while busy");
    writeCfg(1, 1'b0); step(2);
    expectEq(int'(swbEnabled), 0, "R8", "swb bit still written");
    serialBusy = 1'b0;
    writeCfg(1, 1'b1); step(40);
    expectEq(int'(activeDiv), 1, "R8", "write after busy");

    // R9 reset sources
    tag = "R9";
    writeCfg(2, 1'b1); step(40);
    wdtRstReq = 1'b1;
    @(negedge clk) wdtRstReq = 1'b0;
    expectEq(int'(activeDiv), 1, "R9", "watchdog reset");
    expectEq(int'(swbEnabled), 0, "R9", "watchdog swb");
    writeCfg(3, 1'b1); step(40);
    extRstReq = 1'b1;
    @(negedge clk) extRstReq = 1'b0;
    expectEq(int'(activeDiv), 1, "R9", "external reset");
    writeCfg(2, 1'b0); step(40);
    pwrFailReq = 1'b1;
    @(negedge clk) pwrFailReq = 1'b0;
    expectEq(int'(activeDiv), 1, "R9", "power-fail reset");
    measurePeriod(F, "R9");

    step(4);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    if (cycles > 20000) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule